// File: doc/BRIEF.md
# Gain Configuration RAM Port

This block gives a host indirect access to an internal RAM of gain parameters. The RAM holds one record for each mixer input. The host first writes a control word holding an address, a direction and a sequential flag. It then moves words through a data register. With the sequential flag set, the address pointer steps forward after each accepted data access, so a whole record can be streamed without rewriting the address. A busy flag models the write latency of the RAM. Software polls this flag and waits for it to clear before it starts the next access.

Records start at `input_index * REC_STRIDE`. Inside a record, slots 0 to 8 hold the nine polynomial coefficients, slot 9 holds the target gain, slots 10 to 13 hold the four duration parameters, and slot 14 is the apply trigger. When the host writes `TRIG_VAL` into a trigger slot, the block raises a one-cycle commit pulse that carries the input index. On the same edge it copies that record's coefficients, gain and durations into the active parameter outputs that feed the gain stage.

Top module: `gain_ram_port`

## Requirements
- R1: After reset, the control register reads 0x00004000, busy is low and the commit pulse is low.
- R2: The control word has these fields: address in bits [11:0], write direction in bit 12 (1 = write), address-initialise in bit 13 and sequential enable in bit 14. Bit 13 loads the pointer from the address field, or 0 if that value is at least NUM_IN*REC_STRIDE. Bit 13 reads back as 0. With bit 13 clear, the pointer keeps its value. A readback returns the pointer in bits [11:0], the stored direction and sequential bits, and busy in bit 31.
- R3: With `reg_sel` = 1, the data register is selected. In write direction, an accepted data write stores the word at the pointer. `reg_rdata` always shows the word at the pointer.
- R4: With sequential access enabled, the pointer advances by one after each accepted data access and wraps from NUM_IN*REC_STRIDE-1 to 0. With it disabled, the pointer holds.
- R5: An accepted data write sets busy (bit 31) for exactly BUSY_CYC cycles.
- R6: While busy is set, control writes, data writes and data reads are ignored.
- R7: In read direction, a data write is ignored. In write direction, a data read does not move the pointer.
- R8: Input i's record starts at i*REC_STRIDE. Slots 0-8 are coefficients, slot 9 is the gain, slots 10-13 are durations and slot 14 is the trigger.
- R9: Writing TRIG_VAL (1) to a trigger slot gives a one-cycle `commit_o` with `commit_idx_o` = i, and latches record i into `coef_o`, `gain_o` and `dur_o` (word k at bits [32k+31:32k]). Any other value written to the trigger slot commits nothing and leaves the active set unchanged.
- R10: Every record and the active set reset to the default parameters. All coefficients are 0 except coefficient 7, which is 0x1000000. The gain is 0x10000. The durations are 0, 0, 0x400 and 0x8000000. The trigger slot resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data register) |
| reg_sel | input | 1 | 0 = control register, 1 = data register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| commit_o | output | 1 | One-cycle apply pulse |
| commit_idx_o | output | IW | Input index of the last commit |
| coef_o | output | 9*32 | Active polynomial coefficients |
| gain_o | output | 32 | Active target gain |
| dur_o | output | 4*32 | Active duration parameters |

## Verification
Some properties are checked on every cycle: busy follows each accepted write, the pointer is frozen while busy or when sequential access is off, the commit pulse lasts one cycle, and every commit comes from an accepted write. Other behaviour only shows up in the bench's scenarios: the exact length of busy, whether the right data lands at the right address, pointer wrap, the record layout and its defaults, and the contents of the active set after a commit or a rejected trigger. The bench streams random records through the port and also runs directed cases for each of these.

// File: rtl/gain_ram_port.sv
module gain_ram_port #(
  parameter int NUM_IN     = 10,
  parameter int REC_STRIDE = 16,
  parameter int N_COEF     = 9,
  parameter int N_DUR      = 4,
  parameter int BUSY_CYC   = 3,
  parameter int COEF_ONE_SLOT = 7,
  parameter logic [31:0] TRIG_VAL = 32'h1,
  parameter logic [31:0] DEF_COEF = 32'h0100_0000,
  parameter logic [31:0] DEF_GAIN = 32'h0001_0000,
  parameter logic [31:0] DEF_DUR2 = 32'h0000_0400,
  parameter logic [31:0] DEF_DUR3 = 32'h0800_0000,
  localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic                  reg_sel,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  commit_o,
  output logic [IW-1:0]         commit_idx_o,
  output logic [N_COEF*32-1:0]  coef_o,
  output logic [31:0]           gain_o,
  output logic [N_DUR*32-1:0]   dur_o
);
  localparam int DEPTH     = NUM_IN * REC_STRIDE;
  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = $clog2(BUSY_CYC + 1);
  localparam int GAIN_SLOT = N_COEF;
  localparam int DUR_SLOT  = N_COEF + 1;
  localparam int TRIG_SLOT = N_COEF + N_DUR + 1;

  function automatic logic [31:0] def_word(int s);
    if (s == COEF_ONE_SLOT) return DEF_COEF;
    if (s == GAIN_SLOT)     return DEF_GAIN;
    if (s == DUR_SLOT + 2)  return DEF_DUR2;
    if (s == DUR_SLOT + 3)  return DEF_DUR3;
    return '0;
  endfunction

  logic [31:0]   mem   [DEPTH];
  logic [31:0]   act_c [N_COEF];
  logic [31:0]   act_d [N_DUR];
  logic [31:0]   act_g;
  logic [AW-1:0] ptr, slot, base, ptr_inc, ptr_ld;
  logic [IW-1:0] idx;
  logic [CW-1:0] bcnt;
  logic          dir_wr, seq, busy;
  logic          ctl_ok, wr_ok, rd_ok, trig_hit;

  assign busy     = (bcnt != '0);
  assign ctl_ok   = reg_wr & ~reg_sel & ~busy;
  assign wr_ok    = reg_wr &  reg_sel & ~busy &  dir_wr;
  assign rd_ok    = reg_rd &  reg_sel & ~busy & ~dir_wr;
  assign slot     = AW'(32'(ptr) % REC_STRIDE);
  assign idx      = IW'(32'(ptr) / REC_STRIDE);
  assign base     = ptr - slot;
  assign ptr_inc  = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign ptr_ld   = (reg_wdata[11:0] < 12'(DEPTH)) ? AW'(reg_wdata[11:0]) : '0;
  assign trig_hit = wr_ok && (slot == AW'(TRIG_SLOT)) && (reg_wdata == TRIG_VAL);

  assign reg_rdata = reg_sel ? mem[ptr]
                             : {busy, 16'b0, seq, 1'b0, dir_wr, 12'(ptr)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      dir_wr <= 1'b0;
      seq    <= 1'b1;
      bcnt   <= '0;
    end else begin
      if (ctl_ok) begin
        dir_wr <= reg_wdata[12];
        seq    <= reg_wdata[14];
        if (reg_wdata[13]) ptr <= ptr_ld;
      end else if ((wr_ok | rd_ok) & seq) begin
        ptr <= ptr_inc;
      end
      if (wr_ok)          bcnt <= CW'(BUSY_CYC);
      else if (busy)      bcnt <= bcnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= def_word(i % REC_STRIDE);
      for (int k = 0; k < N_COEF; k++) act_c[k] <= def_word(k);
      for (int k = 0; k < N_DUR; k++)  act_d[k] <= def_word(DUR_SLOT + k);
      act_g        <= DEF_GAIN;
      commit_o     <= 1'b0;
      commit_idx_o <= '0;
    end else begin
      commit_o <= trig_hit;
      if (wr_ok) mem[ptr] <= reg_wdata;
      if (trig_hit) begin
        commit_idx_o <= idx;
        for (int k = 0; k < N_COEF; k++) act_c[k] <= mem[base + AW'(k)];
        for (int k = 0; k < N_DUR; k++)  act_d[k] <= mem[base + AW'(DUR_SLOT + k)];
        act_g <= mem[base + AW'(GAIN_SLOT)];
      end
    end
  end

  for (genvar k = 0; k < N_COEF; k++) begin : g_coef
    assign coef_o[k*32 +: 32] = act_c[k];
  end
  for (genvar k = 0; k < N_DUR; k++) begin : g_dur
    assign dur_o[k*32 +: 32] = act_d[k];
  end
  assign gain_o = act_g;

  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> busy);
  a_r6_ptr_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_sel) |=> $stable(ptr));
  a_r4_hold_without_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq && !(reg_wr && !reg_sel)) |=> $stable(ptr));
  a_r9_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
  a_r9_commit_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(wr_ok));
endmodule

// File: tb/sim_gain_ram_port.sv
module sim_gain_ram_port;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 10, ST = 16, DEPTH = NI * ST;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic commit_o;
  logic [3:0] commit_idx_o;
  logic [9*32-1:0] coef_o;
  logic [31:0] gain_o;
  logic [4*32-1:0] dur_o;

  gain_ram_port u0 (.clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata, .reg_rdata,
                    .commit_o, .commit_idx_o, .coef_o, .gain_o, .dur_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] exp_ram [DEPTH];
  logic [31:0] ac [9];
  logic [31:0] ad [4];
  logic [31:0] ag;
  int  eptr = 0;
  bit  edir = 0, eseq = 1;

  function automatic logic [31:0] dflt(int s);
    case (s)
      7: return 32'h0100_0000;
      9: return 32'h0001_0000;
      12: return 32'h0000_0400;
      13: return 32'h0800_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ctl_exp();
    return {1'b0, 16'b0, eseq, 1'b0, edir, 12'(eptr)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_act(input string req);
    bit ok = (gain_o == ag);
    for (int k = 0; k < 9; k++) ok &= (coef_o[k*32 +: 32] == ac[k]);
    for (int k = 0; k < 4; k++) ok &= (dur_o[k*32 +: 32] == ad[k]);
    chk(ok, req, gain_o, ag);
  endtask

  task automatic wait_idle();
    reg_sel = 0; #1;
    while (reg_rdata[31]) begin @(negedge clk); reg_sel = 0; #1; end
  endtask

  task automatic ctl_wr(input int a, input bit d, input bit ini, input bit sq);
    wait_idle();
    @(negedge clk);
    reg_wr = 1; reg_sel = 0; reg_wdata = {17'b0, sq, ini, d, 12'(a)};
    @(negedge clk);
    reg_wr = 0;
    edir = d; eseq = sq;
    if (ini) eptr = (a < DEPTH) ? a : 0;
  endtask

  task automatic adv();
    if (eseq) eptr = (eptr == DEPTH - 1) ? 0 : eptr + 1;
  endtask

  task automatic dat_wr(input logic [31:0] v);
    bit ec = 0;
    int ix = 0;
    wait_idle();
    @(negedge clk);
    reg_wr = 1; reg_sel = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    if (edir) begin
      exp_ram[eptr] = v;
      if ((eptr % ST) == 14 && v == 32'h1) begin
        ec = 1; ix = eptr / ST;
        for (int k = 0; k < 9; k++) ac[k] = exp_ram[ix*ST + k];
        ag = exp_ram[ix*ST + 9];
        for (int k = 0; k < 4; k++) ad[k] = exp_ram[ix*ST + 10 + k];
      end
      adv();
    end
    chk(commit_o == ec, "R9 commit pulse", 32'(commit_o), 32'(ec));
    if (ec) begin
      chk(commit_idx_o == 4'(ix), "R9 commit index", 32'(commit_idx_o), 32'(ix));
      chk_act("R9 active set after commit");
    end
  endtask

  task automatic dat_rd(input string req);
    wait_idle();
    @(negedge clk);
    reg_rd = 1; reg_sel = 1; #1;
    chk(reg_rdata == exp_ram[eptr], req, reg_rdata, exp_ram[eptr]);
    @(negedge clk);
    reg_rd = 0;
    if (!edir) adv();
  endtask

  task automatic ctl_chk(input string req);
    wait_idle();
    chk(reg_rdata == ctl_exp(), req, reg_rdata, ctl_exp());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) exp_ram[i] = dflt(i % ST);
    for (int k = 0; k < 9; k++) ac[k] = dflt(k);
    for (int k = 0; k < 4; k++) ad[k] = dflt(10 + k);
    ag = dflt(9);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(reg_rdata == 32'h0000_4000, "R1 control reset", reg_rdata, 32'h0000_4000);
    chk(commit_o == 1'b0, "R1 commit low", 32'(commit_o), 32'h0);
    // R10 default active set
    chk_act("R10 default active set");
    // R10 R8 default record contents of inputs 0 and 6
    ctl_wr(0, 0, 1, 1);
    for (int s = 0; s < 15; s++) dat_rd("R10 default record word");
    ctl_wr(6*ST, 0, 1, 1);
    for (int s = 0; s < 15; s++) dat_rd("R8 record base of input 6");
    // R2 readback and init/no-init
    ctl_wr(5, 1, 1, 0);
    chk(ctl_exp() == 32'h0000_1005, "R2 model sanity", ctl_exp(), 32'h1005);
    ctl_chk("R2 control readback with init");
    ctl_wr(9, 1, 0, 1);
    ctl_chk("R2 pointer kept without init");
    ctl_wr(12'hFFF, 1, 1, 0);
    ctl_chk("R2 out of range address loads zero");
    // R4 sequential off holds pointer; R3 write then read back
    ctl_wr(5, 1, 1, 0);
    dat_wr(32'hA5A5_0001);
    dat_wr(32'hA5A5_0002);
    ctl_chk("R4 pointer holds with sequential off");
    ctl_wr(5, 0, 1, 0);
    dat_rd("R3 last write stored");
    dat_rd("R4 read with sequential off holds");
    // R5 busy length, R6 ignored accesses while busy
    ctl_wr(20, 1, 1, 1);
    wait_idle();
    @(negedge clk);
    reg_wr = 1; reg_sel = 1; reg_wdata = 32'hDEAD_0014;
    @(negedge clk);
    reg_wr = 0; reg_sel = 0; #1;
    chk(reg_rdata[31] == 1'b1, "R5 busy cycle 1", 32'(reg_rdata[31]), 32'h1);
    reg_wr = 1; reg_wdata = {17'b0, 1'b1, 1'b1, 1'b1, 12'h040};
    @(negedge clk);
    reg_wr = 0; #1;
    chk(reg_rdata[31] == 1'b1, "R5 busy cycle 2", 32'(reg_rdata[31]), 32'h1);
    reg_wr = 1; reg_sel = 1; reg_wdata = 32'hBAD0_BAD0;
    @(negedge clk);
    reg_wr = 0; reg_sel = 0; #1;
    chk(reg_rdata[31] == 1'b1, "R5 busy cycle 3", 32'(reg_rdata[31]), 32'h1);
    @(negedge clk); #1;
    chk(reg_rdata[31] == 1'b0, "R5 busy clears after BUSY_CYC", 32'(reg_rdata[31]), 32'h0);
    exp_ram[20] = 32'hDEAD_0014; eptr = 21; edir = 1; eseq = 1;
    ctl_chk("R6 control write ignored while busy");
    ctl_wr(20, 0, 1, 1);
    dat_rd("R3 word stored at pointer");
    dat_rd("R6 data write ignored while busy");
    // R7 direction gating
    ctl_wr(33, 0, 1, 1);
    dat_wr(32'h1234_5678);
    ctl_chk("R7 write in read direction keeps pointer");
    dat_rd("R7 write in read direction not stored");
    ctl_wr(40, 1, 1, 1);
    dat_rd("R7 read in write direction");
    ctl_chk("R7 read in write direction keeps pointer");
    // R4 wrap
    ctl_wr(DEPTH - 1, 1, 1, 1);
    dat_wr(32'h0000_CAFE);
    ctl_chk("R4 pointer wraps to zero");
    // R9 wrong trigger value then correct
    ctl_wr(3*ST + 9, 1, 1, 0);
    dat_wr(32'h0002_0000);
    ctl_wr(3*ST + 14, 1, 1, 0);
    dat_wr(32'h5);
    chk_act("R9 non-trigger value leaves active set");
    dat_wr(32'h1);
    // R9 instant change on last input
    ctl_wr(9*ST + 10, 1, 1, 1);
    for (int k = 0; k < 4; k++) dat_wr(32'h1);
    dat_wr(32'h1);
    chk(dur_o == {4{32'h1}}, "R9 instant durations", dur_o[31:0], 32'h1);
    // Random records
    for (int it = 0; it < 30; it++) begin
      int ix = $urandom_range(0, NI - 1);
      bit inst = $urandom_range(0, 1) == 1;
      ctl_wr(ix*ST, 1, 1, 1);
      for (int k = 0; k < 9; k++) dat_wr($urandom);
      dat_wr($urandom_range(0, 32'h20000));
      for (int k = 0; k < 4; k++) dat_wr(inst ? 32'h1 : dflt(10 + k));
      dat_wr(32'h1);
      if (it % 5 == 0) begin
        ctl_wr(ix*ST, 0, 1, 1);
        for (int s = 0; s < 15; s++) dat_rd("R8 random record readback");
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule